// File: doc/BRIEF.md
# Branch and Jump Next-PC Unit

This block holds the program counter pair of a 32-bit RISC core that executes one instruction after every control transfer (a single delay slot). It keeps two registers: the address of the instruction now executing and the address of the one that follows it. Each cycle the core presents the instruction word fetched from the current address, together with the values of its two source registers. The unit decodes conditional branches, unconditional jumps and the register jump, and evaluates the branch condition. It then advances the pair.

The current address always takes the old following address, so the instruction after a branch or jump always executes. The following address becomes the transfer target when the transfer is taken, and the next sequential word otherwise. Three link forms ask the register file to write the return address into the link register. The register file, instruction memory and hazard logic sit outside this block.

Top module: `npc_unit`

## Requirements
- R1: While `rst_n` is low, `pc_o` equals the parameter `RESET_VEC` and `npc_o` equals `RESET_VEC + 4`.
- R2: An instruction that is not a control transfer moves `pc_o` to the old `npc_o` and sets `npc_o` to the old `npc_o + 4`. Examples are opcode 0x00 with function code 0x20 and opcode 0x23.
- R3: Opcode 0x04 is taken when `rs_val == rt_val`, and opcode 0x05 is taken when they differ. A taken branch sets `npc_o` to the old `npc_o` plus the sign-extended `instr[15:0]` shifted left by 2. A branch that is not taken sets `npc_o` to the old `npc_o + 4`.
- R4: Opcode 0x06 is taken when `rs_val` is at most zero. Opcode 0x07 is taken when `rs_val` is above zero. Both treat `rs_val` as signed. Either opcode with a nonzero `instr[20:16]` acts as a plain instruction.
- R5: Opcode 0x01 picks a sign test from `instr[20:16]`. The value 0 means below zero, 1 means at least zero, 16 means below zero with link, and 17 means at least zero with link. Any other value acts as a plain instruction.
- R6: Opcodes 0x02 and 0x03 set `npc_o` to the old `npc_o[31:28]`, followed by `instr[25:0]`, followed by two zero bits.
- R7: Opcode 0x00 with function code `instr[5:0] == 0x08` sets `npc_o` to `rs_val`.
- R8: `link_we` is high only during opcode 0x03 and during opcode 0x01 with `instr[20:16]` equal to 16 or 17. This holds whether or not the branch is taken. While `link_we` is high, `link_idx` is 31 and `link_data` is `pc_o + 8`.
- R9: After every cycle out of reset, `pc_o` equals the `npc_o` of the cycle before, which gives exactly one delay slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr | input | 32 | Instruction word at `pc_o` |
| rs_val | input | 32 | Value of the first source register |
| rt_val | input | 32 | Value of the second source register |
| pc_o | output | 32 | Address of the executing instruction |
| npc_o | output | 32 | Address of the following instruction |
| link_we | output | 1 | Request to write the return address |
| link_idx | output | 5 | Register index for the link write |
| link_data | output | 32 | Return address (`pc_o + 8`) |

## Verification
The bench applies signed boundary operands: zero, one and the most negative word. A design that compared these unsigned would take a less-or-equal-zero branch on a positive value, or miss a negative one.

It uses an all-ones branch offset. A design that did not sign-extend it would land far forward instead of one word back. It uses a maximal jump index from a reset vector with nonzero upper bits. A design that drew the region from the wrong address, or dropped the upper bits, would leave the 0x9 region.

It also checks the following cases:
- Sign-test selector values that are not defined must do nothing. A design that decoded only the low bit of the selector would branch on them.
- Less-or-equal-zero with a nonzero second field must not branch.
- A link form that is not taken must still write the link register.
- A jump placed in the delay slot of a taken branch must use the slot address for its region.

// File: rtl/npc_pkg.sv
package npc_pkg;
    localparam int XLEN     = 32;
    localparam int OP_W     = 6;
    localparam int RIDX_W   = 5;
    localparam int FN_W     = 6;
    localparam int OFF_W    = 16;
    localparam int IDX_W    = 26;
    localparam int REGION_W = XLEN - IDX_W - 2;
    localparam int SEXT_W   = XLEN - OFF_W - 2;
    localparam int WORD_B   = 4;

    localparam logic [OP_W-1:0] OP_SPECIAL = 6'h00;
    localparam logic [OP_W-1:0] OP_SIGNTST = 6'h01;
    localparam logic [OP_W-1:0] OP_JUMP    = 6'h02;
    localparam logic [OP_W-1:0] OP_JUMPLNK = 6'h03;
    localparam logic [OP_W-1:0] OP_BREQ    = 6'h04;
    localparam logic [OP_W-1:0] OP_BRNE    = 6'h05;
    localparam logic [OP_W-1:0] OP_BRLEZ   = 6'h06;
    localparam logic [OP_W-1:0] OP_BRGTZ   = 6'h07;
    localparam logic [FN_W-1:0] FN_JREG    = 6'h08;

    typedef enum logic [2:0] {
        C_NEVER, C_ALWAYS, C_EQ, C_NE, C_LEZ, C_GTZ, C_LTZ, C_GEZ
    } cond_e;

    typedef enum logic [1:0] {
        T_SEQ, T_REL, T_REGION, T_REG
    } tgt_e;

    typedef struct packed {
        cond_e cond;
        tgt_e  tgt;
        logic  link;
    } ctrl_t;

    typedef struct packed {
        logic [XLEN-1:0] pc;
        logic [XLEN-1:0] npc;
    } pcpair_t;
endpackage

// File: rtl/npc_decode.sv
module npc_decode
    import npc_pkg::*;
(
    input  logic [OP_W-1:0]   op,
    input  logic [RIDX_W-1:0] rt_fld,
    input  logic [FN_W-1:0]   fn,
    output ctrl_t             ctrl
);
    always_comb begin
        ctrl = '{cond: C_NEVER, tgt: T_SEQ, link: 1'b0};
        unique case (op)
            OP_SPECIAL: begin
                if (fn == FN_JREG) begin
                    ctrl.cond = C_ALWAYS;
                    ctrl.tgt  = T_REG;
                end
            end
            OP_SIGNTST: begin
                // bit 4 selects the link form, bit 0 the test polarity
                if (rt_fld[3:1] == 3'b000) begin
                    ctrl.cond = rt_fld[0] ? C_GEZ : C_LTZ;
                    ctrl.tgt  = T_REL;
                    ctrl.link = rt_fld[4];
                end
            end
            OP_JUMP: begin
                ctrl.cond = C_ALWAYS;
                ctrl.tgt  = T_REGION;
            end
            OP_JUMPLNK: begin
                ctrl.cond = C_ALWAYS;
                ctrl.tgt  = T_REGION;
                ctrl.link = 1'b1;
            end
            OP_BREQ: begin
                ctrl.cond = C_EQ;
                ctrl.tgt  = T_REL;
            end
            OP_BRNE: begin
                ctrl.cond = C_NE;
                ctrl.tgt  = T_REL;
            end
            OP_BRLEZ: begin
                if (rt_fld == '0) begin
                    ctrl.cond = C_LEZ;
                    ctrl.tgt  = T_REL;
                end
            end
            OP_BRGTZ: begin
                if (rt_fld == '0) begin
                    ctrl.cond = C_GTZ;
                    ctrl.tgt  = T_REL;
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/npc_cond.sv
module npc_cond
    import npc_pkg::*;
(
    input  cond_e           cond,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic            taken
);
    logic neg, zero;

    always_comb begin
        neg  = a[XLEN-1];
        zero = (a == '0);
        unique case (cond)
            C_ALWAYS: taken = 1'b1;
            C_EQ:     taken = (a == b);
            C_NE:     taken = (a != b);
            C_LEZ:    taken = neg | zero;
            C_GTZ:    taken = ~neg & ~zero;
            C_LTZ:    taken = neg;
            C_GEZ:    taken = ~neg;
            default:  taken = 1'b0;
        endcase
    end
endmodule

// File: rtl/npc_target.sv
module npc_target
    import npc_pkg::*;
(
    input  tgt_e             tgt,
    input  logic [XLEN-1:0]  slot_pc,
    input  logic [XLEN-1:0]  reg_val,
    input  logic [IDX_W-1:0] field,
    output logic [XLEN-1:0]  addr
);
    logic [OFF_W-1:0] off;
    logic [XLEN-1:0]  rel_add;

    always_comb begin
        off     = field[OFF_W-1:0];
        rel_add = {{SEXT_W{off[OFF_W-1]}}, off, 2'b00};
        unique case (tgt)
            T_REL:    addr = slot_pc + rel_add;
            T_REGION: addr = {slot_pc[XLEN-1 -: REGION_W], field, 2'b00};
            T_REG:    addr = reg_val;
            default:  addr = slot_pc + XLEN'(WORD_B);
        endcase
    end
endmodule

// File: rtl/npc_unit.sv
module npc_unit
    import npc_pkg::*;
#(
    parameter logic [31:0] RESET_VEC = 32'h9000_0100,
    parameter int          LINK_REG  = 31
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [XLEN-1:0]     instr,
    input  logic [XLEN-1:0]     rs_val,
    input  logic [XLEN-1:0]     rt_val,
    output logic [XLEN-1:0]     pc_o,
    output logic [XLEN-1:0]     npc_o,
    output logic                link_we,
    output logic [RIDX_W-1:0]   link_idx,
    output logic [XLEN-1:0]     link_data
);
    localparam logic [XLEN-1:0] RESET_NEXT = RESET_VEC + XLEN'(WORD_B);

    pcpair_t         st_d, st_q;
    ctrl_t           ctrl;
    logic            taken;
    logic [XLEN-1:0] tgt_addr;

    npc_decode u_dec (
        .op     (instr[XLEN-1 -: OP_W]),
        .rt_fld (instr[20:16]),
        .fn     (instr[FN_W-1:0]),
        .ctrl   (ctrl)
    );

    npc_cond u_cond (
        .cond  (ctrl.cond),
        .a     (rs_val),
        .b     (rt_val),
        .taken (taken)
    );

    npc_target u_tgt (
        .tgt     (ctrl.tgt),
        .slot_pc (st_q.npc),
        .reg_val (rs_val),
        .field   (instr[IDX_W-1:0]),
        .addr    (tgt_addr)
    );

    always_comb begin
        st_d.pc  = st_q.npc;
        st_d.npc = taken ? tgt_addr : st_q.npc + XLEN'(WORD_B);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pc  <= RESET_VEC;
            st_q.npc <= RESET_NEXT;
        end else begin
            st_q <= st_d;
        end
    end

    assign pc_o      = st_q.pc;
    assign npc_o     = st_q.npc;
    assign link_we   = ctrl.link;
    assign link_idx  = RIDX_W'(LINK_REG);
    assign link_data = st_q.pc + XLEN'(2 * WORD_B);
endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk
    import npc_pkg::*;
#(
    parameter logic [31:0] RESET_VEC = 32'h9000_0100
) (
    input logic              clk,
    input logic              rst_n,
    input logic [XLEN-1:0]   instr,
    input logic [XLEN-1:0]   rs_val,
    input logic [XLEN-1:0]   pc_o,
    input logic [XLEN-1:0]   npc_o,
    input logic              link_we
);
    logic [OP_W-1:0] op;
    assign op = instr[XLEN-1 -: OP_W];

    // R1
    reset_vec_chk: assert property (@(posedge clk)
        !rst_n |=> (pc_o == RESET_VEC) && (npc_o == RESET_VEC + 32'd4));

    // R9
    delay_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> pc_o == $past(npc_o));

    // R2
    seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op >= 6'h08) |=> npc_o == $past(npc_o) + 32'd4);

    // R7
    reg_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 6'h00 && instr[5:0] == 6'h08) |=> npc_o == $past(rs_val));

    // R6
    region_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 6'h02 || op == 6'h03) |=>
            (npc_o[31:28] == $past(npc_o[31:28])) && (npc_o[1:0] == 2'b00));

    // R8
    link_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        link_we |-> (op == 6'h03) ||
                    (op == 6'h01 && instr[20] && instr[19:17] == 3'b000));
endmodule

bind npc_unit npc_unit_chk #(.RESET_VEC(RESET_VEC)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .instr   (instr),
    .rs_val  (rs_val),
    .pc_o    (pc_o),
    .npc_o   (npc_o),
    .link_we (link_we)
);

// File: tb/sim_npc_unit.sv
`timescale 1ns/1ps
module sim_npc_unit;
    localparam logic [31:0] RV   = 32'h9000_0100;
    localparam logic [31:0] SLOT = 32'h9000_0104;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] instr = 32'h0;
    logic [31:0] rs_val = 32'h0;
    logic [31:0] rt_val = 32'h0;
    logic [31:0] pc_o, npc_o, link_data;
    logic        link_we;
    logic [4:0]  link_idx;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    npc_unit #(.RESET_VEC(RV)) u0 (
        .clk(clk), .rst_n(rst_n), .instr(instr), .rs_val(rs_val),
        .rt_val(rt_val), .pc_o(pc_o), .npc_o(npc_o), .link_we(link_we),
        .link_idx(link_idx), .link_data(link_data)
    );

    typedef struct packed {
        logic [31:0] ins;
        logic [31:0] rs;
        logic [31:0] rt;
        logic [31:0] exp_npc;
        logic        exp_link;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t VECS [NV] = '{
        // R3 equal / not-equal comparisons, offset +4 words
        '{32'h1022_0004, 32'h5, 32'h5, 32'h9000_0114, 1'b0, 4'd3},
        '{32'h1022_0004, 32'h5, 32'h6, 32'h9000_0108, 1'b0, 4'd3},
        '{32'h1422_0004, 32'h5, 32'h6, 32'h9000_0114, 1'b0, 4'd3},
        '{32'h1422_0004, 32'h7, 32'h7, 32'h9000_0108, 1'b0, 4'd3},
        // R4 signed zero tests, offset -1 word
        '{32'h1820_FFFF, 32'h0, 32'h0, 32'h9000_0100, 1'b0, 4'd4},
        '{32'h1820_FFFF, 32'h1, 32'h0, 32'h9000_0108, 1'b0, 4'd4},
        '{32'h1820_FFFF, 32'h8000_0000, 32'h0, 32'h9000_0100, 1'b0, 4'd4},
        '{32'h1C20_FFFF, 32'h1, 32'h0, 32'h9000_0100, 1'b0, 4'd4},
        '{32'h1C20_FFFF, 32'h0, 32'h0, 32'h9000_0108, 1'b0, 4'd4},
        '{32'h1C20_FFFF, 32'h8000_0000, 32'h0, 32'h9000_0108, 1'b0, 4'd4},
        '{32'h1821_FFFF, 32'h0, 32'h0, 32'h9000_0108, 1'b0, 4'd4},
        // R5 sign-test selector
        '{32'h0420_0004, 32'hFFFF_FFFF, 32'h0, 32'h9000_0114, 1'b0, 4'd5},
        '{32'h0420_0004, 32'h0, 32'h0, 32'h9000_0108, 1'b0, 4'd5},
        '{32'h0421_0004, 32'h0, 32'h0, 32'h9000_0114, 1'b0, 4'd5},
        '{32'h0421_0004, 32'h8000_0000, 32'h0, 32'h9000_0108, 1'b0, 4'd5},
        // R8 link forms, taken and not taken
        '{32'h0430_0004, 32'h1, 32'h0, 32'h9000_0108, 1'b1, 4'd8},
        '{32'h0431_0004, 32'h1, 32'h0, 32'h9000_0114, 1'b1, 4'd8},
        '{32'h0422_0004, 32'h0, 32'h0, 32'h9000_0108, 1'b0, 4'd5},
        // R6 region jumps
        '{32'h0800_0040, 32'h0, 32'h0, 32'h9000_0100, 1'b0, 4'd6},
        '{32'h0BFF_FFFF, 32'h0, 32'h0, 32'h9FFF_FFFC, 1'b0, 4'd6},
        '{32'h0C00_0040, 32'h0, 32'h0, 32'h9000_0100, 1'b1, 4'd8},
        // R7 register jump
        '{32'h0020_0008, 32'h1234_5678, 32'h0, 32'h1234_5678, 1'b0, 4'd7},
        // R2 plain instructions
        '{32'h0022_1820, 32'h0, 32'h0, 32'h9000_0108, 1'b0, 4'd2},
        '{32'h8C22_0000, 32'h0, 32'h0, 32'h9000_0108, 1'b0, 4'd2}
    };

    task automatic chk(input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        instr = 32'h0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic step(input logic [31:0] i, input logic [31:0] a,
                        input logic [31:0] b);
        instr  = i;
        rs_val = a;
        rt_val = b;
    endtask

    initial begin
        repeat (2) @(negedge clk);
        // R1 reset state
        chk("R1 pc", pc_o, RV);
        chk("R1 npc", npc_o, SLOT);

        for (int k = 0; k < NV; k++) begin
            do_reset();
            step(VECS[k].ins, VECS[k].rs, VECS[k].rt);
            #1;
            chk($sformatf("R%0d link_we v%0d", VECS[k].req, k),
                {31'b0, link_we}, {31'b0, VECS[k].exp_link});
            if (VECS[k].exp_link) begin
                chk($sformatf("R8 link_data v%0d", k), link_data, 32'h9000_0108);
                chk($sformatf("R8 link_idx v%0d", k), {27'b0, link_idx}, 32'd31);
            end
            @(negedge clk);
            chk($sformatf("R9 pc v%0d", k), pc_o, SLOT);
            chk($sformatf("R%0d npc v%0d", VECS[k].req, k), npc_o, VECS[k].exp_npc);
        end

        // R9 jump in the delay slot of a taken branch uses the slot region
        do_reset();
        step(32'h1022_0004, 32'h3, 32'h3);
        @(negedge clk);
        chk("R9 seq pc1", pc_o, SLOT);
        chk("R3 seq npc1", npc_o, 32'h9000_0114);
        step(32'h0C00_0040, 32'h0, 32'h0);
        #1;
        chk("R8 seq link_data", link_data, 32'h9000_010C);
        @(negedge clk);
        chk("R9 seq pc2", pc_o, 32'h9000_0114);
        chk("R6 seq npc2", npc_o, 32'h9000_0100);
        step(32'h8C22_0000, 32'h0, 32'h0);
        @(negedge clk);
        chk("R9 seq pc3", pc_o, 32'h9000_0100);
        chk("R2 seq npc3", npc_o, 32'h9000_0104);

        // R1 reset in the middle of a run restores the vector
        rst_n = 1'b0;
        #1;
        chk("R1 mid pc", pc_o, RV);
        chk("R1 mid npc", npc_o, SLOT);
        @(negedge clk);
        rst_n = 1'b1;

        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog act=hung exp=done");
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule